// File: doc/BRIEF.md
# SIMT Lane Reconvergence Tracker

This block follows the control flow of a small group of threads that share one instruction stream. It holds a scalar clause pointer, an execution mask of the lanes that currently run, and one stored clause pointer per lane. A lane that is switched off keeps, in its stored pointer, the clause address where it will rejoin the group. The block keeps the scalar pointer equal to the smallest pointer of any lane, and the mask holds exactly the lanes sitting at that smallest pointer. This removes the need for a divergence stack.

Each time a clause finishes, the sequencer pulses `clauseDone`. It also presents a fast-path flag, one branch-taken bit per lane and a single branch target. When the fast-path flag is set, only the scalar pointer moves on by one clause step. When the flag is clear, the block works out the next pointer of every running lane and writes it into the per-lane store. It then takes the minimum over all lanes through a compare tree and rebuilds the mask. The fetch side must clear the fast-path flag on any clause that branches. It must also clear it on any clause that falls through into an address where parked lanes may be waiting, because only the full resolution brings them back.

Top module: `simt_reconverge_unit`

## Requirements
- R1: When `rstN` is low, the scalar pointer and every lane pointer are set to `RESET_PC`, and all `LANES` mask bits are 1.
- R2: On a clock edge where `clauseDone` is 0, the scalar pointer, the mask and every lane pointer keep their values, whatever the other inputs are.
- R3: On a clock edge where `clauseDone` and `backToBack` are both 1, the scalar pointer becomes its old value plus `CLAUSE_STEP`. The mask and the stored pointers of the parked lanes do not change, and `takenMask` and `target` are ignored.
- R4: On a clock edge where `clauseDone` is 1 and `backToBack` is 0, each lane whose mask bit is 1 gets a new pointer. The new pointer is `target` if that lane's `takenMask` bit is 1, and the old scalar pointer plus `CLAUSE_STEP` if the bit is 0.
- R5: During a resolution, a lane whose mask bit is 0 keeps its stored pointer, and its `takenMask` bit has no effect.
- R6: After a resolution, the scalar pointer equals the minimum of all lane pointers.
- R7: After a resolution, mask bit i is 1 exactly when lane i's pointer equals the new scalar pointer. The mask is therefore never all zero, and every lane whose mask bit is 0 has a pointer greater than the scalar pointer.
- R8: For each lane i whose mask bit is 1, the bits [i*PC_W +: PC_W] of `lanePc` show the current scalar pointer. For a lane whose mask bit is 0, those bits show its stored pointer.
- R9: Every update becomes visible on the outputs right after the clock edge that samples `clauseDone` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clauseDone | input | 1 | One-cycle strobe marking the end of a clause |
| backToBack | input | 1 | Fast path: advance the scalar pointer only |
| takenMask | input | LANES | Per-lane branch-taken bits for the finishing clause |
| target | input | PC_W | Branch target address of the finishing clause |
| scalarPc | output | PC_W | Current scalar clause pointer (the minimum over lanes) |
| execMask | output | LANES | Lanes executing at the scalar pointer |
| lanePc | output | LANES*PC_W | Per-lane pointer view, lane i at bits [i*PC_W +: PC_W] |

## Verification
The hardest state to reach is a three-way split. In this state one lane is parked far ahead, a second group is parked at a nearer rejoin point, and the running group has to step through resolutions one clause at a time until each group is absorbed in order. The stimulus builds this state from a diverged group with a sequence of partial branches. It then sends resolutions with no taken lanes and checks the mask as it widens at each rejoin address. Taken bits are also driven on parked lanes, and during fast-path clauses, so that the bench can show at the pointer outputs that those bits are ignored.

// File: rtl/simt_reconverge_pkg.sv
package simt_reconverge_pkg;

  // Strobes from the clause controller to the pointer datapath
  typedef struct packed {
    logic advance;   // fast path: scalar pointer steps on by one clause
    logic resolve;   // full per-lane resolution
  } clause_ctl_t;

endpackage

// File: rtl/srcu_clause_ctrl.sv
module srcu_clause_ctrl
  import simt_reconverge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clauseDone,
  input  logic        backToBack,
  output clause_ctl_t ctl
);

  always_comb begin
    ctl = '0;
    if (rstN && clauseDone) begin
      if (backToBack) ctl.advance = 1'b1;
      else            ctl.resolve = 1'b1;
    end
  end

  // R3 / R4: exactly one path per finished clause, none otherwise
  one_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.advance, ctl.resolve}));

  // R2
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clauseDone |-> !(ctl.advance || ctl.resolve));

endmodule

// File: rtl/srcu_min_tree.sv
module srcu_min_tree #(
  parameter int LANES = 4,
  parameter int PC_W  = 16
) (
  input  logic [PC_W-1:0] leafPc [LANES],
  output logic [PC_W-1:0] minPc
);

  localparam int NODES = 2 * LANES - 1;
  localparam int FIRST_LEAF = LANES - 1;

  logic [PC_W-1:0] node [NODES];

  for (genvar i = 0; i < LANES; i++) begin : g_leaf
    assign node[FIRST_LEAF + i] = leafPc[i];
  end

  for (genvar k = 0; k < FIRST_LEAF; k++) begin : g_cmp
    assign node[k] = (node[2*k+2] < node[2*k+1]) ? node[2*k+2] : node[2*k+1];
  end

  assign minPc = node[0];

endmodule

// File: rtl/srcu_pc_datapath.sv
module srcu_pc_datapath
  import simt_reconverge_pkg::*;
#(
  parameter int              LANES       = 4,
  parameter int              PC_W        = 16,
  parameter logic [PC_W-1:0] RESET_PC    = '0,
  parameter int              CLAUSE_STEP = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  clause_ctl_t       ctl,
  input  logic [LANES-1:0]  takenMask,
  input  logic [PC_W-1:0]   target,
  output logic [PC_W-1:0]   scalarPc,
  output logic [LANES-1:0]  execMask,
  output logic [LANES*PC_W-1:0] lanePc
);

  localparam logic [PC_W-1:0] STEP = PC_W'(CLAUSE_STEP);

  logic [PC_W-1:0]  storedPc [LANES];
  logic [PC_W-1:0]  nextPc   [LANES];
  logic [PC_W-1:0]  seqPc;
  logic [PC_W-1:0]  minPc;
  logic [LANES-1:0] nextMask;

  assign seqPc = scalarPc + STEP;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      if (execMask[i]) nextPc[i] = takenMask[i] ? target : seqPc;
      else             nextPc[i] = storedPc[i];
    end

    assign nextMask[i] = (nextPc[i] == minPc);

    always_ff @(posedge clk) begin
      if (!rstN)            storedPc[i] <= RESET_PC;
      else if (ctl.resolve) storedPc[i] <= nextPc[i];
    end

    // running lanes show the live scalar pointer, parked lanes their rejoin point
    assign lanePc[i*PC_W +: PC_W] = execMask[i] ? scalarPc : storedPc[i];

    // R7: a parked lane always waits above the scalar pointer
    parked_above_chk: assert property (@(posedge clk) disable iff (!rstN)
      !execMask[i] |-> (storedPc[i] > scalarPc));

    // R5: a parked lane keeps its pointer through a resolution
    parked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.resolve && !execMask[i]) |=> (storedPc[i] == $past(storedPc[i])));
  end

  srcu_min_tree #(.LANES(LANES), .PC_W(PC_W)) u_min (
    .leafPc (nextPc),
    .minPc  (minPc)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scalarPc <= RESET_PC;
      execMask <= '1;
    end else if (ctl.resolve) begin
      scalarPc <= minPc;
      execMask <= nextMask;
    end else if (ctl.advance) begin
      scalarPc <= seqPc;
    end
  end

  // R7
  mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    execMask != '0);

  // R3
  fast_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> (scalarPc == PC_W'($past(scalarPc) + STEP)) && $stable(execMask));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.advance || ctl.resolve) |=> $stable(scalarPc) && $stable(execMask));

endmodule

// File: rtl/simt_reconverge_unit.sv
module simt_reconverge_unit
  import simt_reconverge_pkg::*;
#(
  parameter int              LANES       = 4,
  parameter int              PC_W        = 16,
  parameter logic [PC_W-1:0] RESET_PC    = 16'h0100,
  parameter int              CLAUSE_STEP = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clauseDone,
  input  logic                  backToBack,
  input  logic [LANES-1:0]      takenMask,
  input  logic [PC_W-1:0]       target,
  output logic [PC_W-1:0]       scalarPc,
  output logic [LANES-1:0]      execMask,
  output logic [LANES*PC_W-1:0] lanePc
);

  clause_ctl_t ctl;

  srcu_clause_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .clauseDone (clauseDone),
    .backToBack (backToBack),
    .ctl        (ctl)
  );

  srcu_pc_datapath #(
    .LANES       (LANES),
    .PC_W        (PC_W),
    .RESET_PC    (RESET_PC),
    .CLAUSE_STEP (CLAUSE_STEP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .takenMask (takenMask),
    .target    (target),
    .scalarPc  (scalarPc),
    .execMask  (execMask),
    .lanePc    (lanePc)
  );

endmodule

// File: tb/sim_simt_reconverge_unit.sv
module sim_simt_reconverge_unit;

  localparam int LANES = 4;
  localparam int PC_W  = 16;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  clauseDone = 1'b0;
  logic                  backToBack = 1'b0;
  logic [LANES-1:0]      takenMask = '0;
  logic [PC_W-1:0]       target = '0;
  logic [PC_W-1:0]       scalarPc;
  logic [LANES-1:0]      execMask;
  logic [LANES*PC_W-1:0] lanePc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  simt_reconverge_unit #(.LANES(LANES), .PC_W(PC_W), .RESET_PC(16'h0100), .CLAUSE_STEP(1)) u0 (
    .clk(clk), .rstN(rstN), .clauseDone(clauseDone), .backToBack(backToBack),
    .takenMask(takenMask), .target(target),
    .scalarPc(scalarPc), .execMask(execMask), .lanePc(lanePc)
  );

  task automatic expectState(string req, logic [PC_W-1:0] expPc, logic [LANES-1:0] expMask,
                             logic [PC_W-1:0] l0, logic [PC_W-1:0] l1,
                             logic [PC_W-1:0] l2, logic [PC_W-1:0] l3);
    logic [LANES*PC_W-1:0] expLanes;
    expLanes = {l3, l2, l1, l0};
    checks++;
    if (scalarPc !== expPc || execMask !== expMask || lanePc !== expLanes) begin
      failures++;
      $display("FAIL %s: actual pc=%h mask=%b lanes=%h, expected pc=%h mask=%b lanes=%h",
               req, scalarPc, execMask, lanePc, expPc, expMask, expLanes);
    end
  endtask

  // one clause end, outputs sampled on the negedge after the capturing posedge (R9)
  task automatic endClause(logic bb, logic [LANES-1:0] tk, logic [PC_W-1:0] tgt);
    @(negedge clk);
    clauseDone = 1'b1; backToBack = bb; takenMask = tk; target = tgt;
    @(negedge clk);
    clauseDone = 1'b0; takenMask = '0; backToBack = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  task automatic testReset();
    doReset();
    expectState("R1 reset", 16'h0100, 4'b1111, 16'h0100, 16'h0100, 16'h0100, 16'h0100);
  endtask

  task automatic testFastPath();
    endClause(1'b1, 4'b0101, 16'h0200);
    expectState("R3 fast path ignores taken", 16'h0101, 4'b1111, 16'h0101, 16'h0101, 16'h0101, 16'h0101);
    endClause(1'b1, 4'b1111, 16'h0050);
    expectState("R3 R9 second fast step", 16'h0102, 4'b1111, 16'h0102, 16'h0102, 16'h0102, 16'h0102);
  endtask

  task automatic testIdle();
    @(negedge clk);
    backToBack = 1'b0; takenMask = 4'b1111; target = 16'h0010;
    @(negedge clk); @(negedge clk);
    expectState("R2 idle with inputs driven", 16'h0102, 4'b1111, 16'h0102, 16'h0102, 16'h0102, 16'h0102);
    takenMask = '0;
  endtask

  task automatic testDivergeRejoin();
    endClause(1'b0, 4'b0011, 16'h0110);
    expectState("R4 R6 R7 diverge", 16'h0103, 4'b1100, 16'h0110, 16'h0110, 16'h0103, 16'h0103);
    endClause(1'b1, 4'b0000, 16'h0000);
    expectState("R3 R8 fast while diverged", 16'h0104, 4'b1100, 16'h0110, 16'h0110, 16'h0104, 16'h0104);
    for (int n = 0; n < 11; n++) endClause(1'b1, 4'b0000, 16'h0000);
    expectState("R3 walk to 10F", 16'h010F, 4'b1100, 16'h0110, 16'h0110, 16'h010F, 16'h010F);
    endClause(1'b0, 4'b0000, 16'h0000);
    expectState("R7 fall-through rejoin", 16'h0110, 4'b1111, 16'h0110, 16'h0110, 16'h0110, 16'h0110);
  endtask

  task automatic testUniformBranch();
    endClause(1'b0, 4'b1111, 16'h00F0);
    expectState("R4 R6 all taken backward", 16'h00F0, 4'b1111, 16'h00F0, 16'h00F0, 16'h00F0, 16'h00F0);
  endtask

  task automatic testParkedIgnored();
    endClause(1'b0, 4'b0001, 16'h00F8);
    expectState("R4 R7 lane0 parked ahead", 16'h00F1, 4'b1110, 16'h00F8, 16'h00F1, 16'h00F1, 16'h00F1);
    endClause(1'b0, 4'b0001, 16'h00F2);
    expectState("R5 parked taken ignored", 16'h00F2, 4'b1110, 16'h00F8, 16'h00F2, 16'h00F2, 16'h00F2);
  endtask

  task automatic testThreeWay();
    endClause(1'b0, 4'b0100, 16'h00F5);
    expectState("R6 R7 three-way split", 16'h00F3, 4'b1010, 16'h00F8, 16'h00F3, 16'h00F5, 16'h00F3);
    endClause(1'b0, 4'b0000, 16'h0000);
    expectState("R4 step F4", 16'h00F4, 4'b1010, 16'h00F8, 16'h00F4, 16'h00F5, 16'h00F4);
    endClause(1'b0, 4'b0000, 16'h0000);
    expectState("R7 lane2 rejoins", 16'h00F5, 4'b1110, 16'h00F8, 16'h00F5, 16'h00F5, 16'h00F5);
    endClause(1'b0, 4'b0000, 16'h0000);
    endClause(1'b0, 4'b0000, 16'h0000);
    expectState("R5 lane0 still parked", 16'h00F7, 4'b1110, 16'h00F8, 16'h00F7, 16'h00F7, 16'h00F7);
    endClause(1'b0, 4'b0000, 16'h0000);
    expectState("R7 full rejoin", 16'h00F8, 4'b1111, 16'h00F8, 16'h00F8, 16'h00F8, 16'h00F8);
  endtask

  task automatic testMidReset();
    endClause(1'b0, 4'b1010, 16'h0300);
    expectState("R4 R7 split before reset", 16'h00F9, 4'b0101, 16'h00F9, 16'h0300, 16'h00F9, 16'h0300);
    testReset();
  endtask

  initial begin
    testReset();
    testFastPath();
    testIdle();
    testDivergeRejoin();
    testUniformBranch();
    testParkedIgnored();
    testThreeWay();
    testMidReset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule